// File: doc/BRIEF.md
# Change-Triggered Logic Capture Engine

This block watches a group of digital channels and stores a record in an external sample memory only when the channel levels change. It does not store every sample. A free-running divider turns the system clock into a sample strobe. The channels pass through a synchronizer and are sampled on each strobe. A sample is compared with the pattern in the last stored record, and a new record is written only when the two differ. Each record holds three fields: the channel levels, a delta timestamp, and a status byte. The timestamp counts how many sample strobes went by without a record since the previous one.

Software or a host controller drives three pulse inputs: start, stop and clear. It reads the current write count and two flags, running and full. The memory write port is synchronous: one address, one data word and one write enable, each registered. When the last memory location has been written, capture halts by itself and the full flag is raised. Clear is the only way out of the full state.

With the default parameters the block has 8 channels and a 32-bit record. The divider is 32, which gives a 6.25 MHz sample rate from a 200 MHz clock. The memory holds 262144 records, addressed with 18 bits.

Top module: `xcap_top`

## Requirements
- R1: Each channel passes through a synchronizer of at least two flops before it is compared. A level applied at the pins reaches the comparison SYNC_STAGES clocks later.
- R2: A sample is taken once every TICK_DIV clocks. The divider counts freely from reset, and 32 is the default.
- R3: While running, a record is written on a sample only if the synchronized channel pattern differs from the pattern in the last stored record, or if R6 or R7 applies.
- R4: The record layout is channel data in the top NCH bits, then the TS_W-bit timestamp, then the ST_W-bit status in the low bits. With the defaults this is [31:24] data, [23:8] timestamp and [7:0] status.
- R5: The timestamp of a record is the number of samples taken since the previous record that produced no record. It returns to 0 after every store and at start.
- R6: When the timestamp is at its all-ones value and nothing else forces a store, a filler record is written with status bit 0 set.
- R7: The first sample after a start is always stored. It carries status bit 1 and a timestamp of 0.
- R8: Writing address 2**ADDR_W-1 sets full and clears running. A start is ignored while full is set.
- R9: Clear takes effect in one clock. It zeroes the write count, full, running and the timestamp, and the next start opens a new capture at address 0.
- R10: Stop clears running and blocks further writes, and stop wins over a sample strobe in the same clock. A later start resumes at the current address.
- R11: Records go to consecutive addresses starting at 0. The write count equals the number of records stored since reset or clear. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Pulse to begin or resume capture |
| stop_i | input | 1 | Pulse to halt capture |
| clear_i | input | 1 | Pulse to empty the capture memory state |
| chan_i | input | NCH | Asynchronous channel inputs |
| mem_addr_o | output | ADDR_W | Memory write address |
| mem_wdata_o | output | NCH+TS_W+ST_W | Record to be written |
| mem_we_o | output | 1 | Memory write enable, one clock per record |
| wr_count_o | output | ADDR_W+1 | Number of records stored |
| running_o | output | 1 | Capture is active |
| full_o | output | 1 | Memory is full, capture halted |

## Verification
Several properties are checked on every clock. Full and running are never both set. Each write lands at one below the write count. Writes happen only while running. A first record has a zero timestamp. A plain record always differs from the previous stored pattern. Clear and stop act in the following clock. The exact clock in which a record is written depends on the synchronizer delay, the strobe phase and the overflow point, so only the bench's reference model can show it. The same holds for the timestamp values, for resume after stop, and for the filler and full sequences. The bench runs the design with a short timestamp and a small memory so that it reaches the filler and full cases.

// File: rtl/xcap_pkg.sv
package xcap_pkg;
   localparam int STAT_OVF_BIT   = 0;
   localparam int STAT_FIRST_BIT = 1;
endpackage

// File: rtl/xcap_sync.sv
module xcap_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("xcap_sync: STAGES must be at least 2");
   end

   logic [W-1:0] pipe [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[s] <= '0;
         else        pipe[s] <= (s == 0) ? d_i : pipe[(s == 0) ? 0 : s-1];
      end
   end

   assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/xcap_tick.sv
module xcap_tick #(
   parameter int DIV = 32
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick_o
);
   if (DIV < 1) begin : g_bad_div
      $error("xcap_tick: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_every
      assign tick_o = 1'b1;
   end else begin : g_count
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                      cnt <= '0;
         else if (cnt == CW'(DIV - 1))    cnt <= '0;
         else                             cnt <= cnt + 1'b1;
      end
      assign tick_o = (cnt == CW'(DIV - 1));
   end
endmodule

// File: rtl/xcap_record.sv
module xcap_record
   import xcap_pkg::*;
#(
   parameter int NCH    = 8,
   parameter int TS_W   = 16,
   parameter int ST_W   = 8,
   parameter int ADDR_W = 18,
   localparam int REC_W = NCH + TS_W + ST_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              clear_i,
   input  logic              tick_i,
   input  logic [NCH-1:0]    chan_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [REC_W-1:0]  mem_wdata_o,
   output logic              mem_we_o,
   output logic [ADDR_W:0]   wr_count_o,
   output logic              running_o,
   output logic              full_o
);
   localparam logic [ADDR_W:0]  LAST_ADDR = (ADDR_W+1)'((1 << ADDR_W) - 1);
   localparam logic [TS_W-1:0]  TS_MAX    = '1;

   logic [ADDR_W:0]  count_q;
   logic [NCH-1:0]   last_q;
   logic [TS_W-1:0]  ts_q;
   logic             first_q;
   logic             changed, ovf, do_store;
   logic [ST_W-1:0]  stat;

   always_comb begin
      changed  = (chan_i != last_q);
      ovf      = (ts_q == TS_MAX);
      do_store = first_q | changed | ovf;
      stat     = '0;
      stat[STAT_OVF_BIT]   = ovf & ~first_q & ~changed;
      stat[STAT_FIRST_BIT] = first_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q     <= '0;
         last_q      <= '0;
         ts_q        <= '0;
         first_q     <= 1'b0;
         running_o   <= 1'b0;
         full_o      <= 1'b0;
         mem_we_o    <= 1'b0;
         mem_addr_o  <= '0;
         mem_wdata_o <= '0;
      end else begin
         mem_we_o <= 1'b0;
         if (clear_i) begin
            count_q   <= '0;
            last_q    <= '0;
            ts_q      <= '0;
            first_q   <= 1'b0;
            running_o <= 1'b0;
            full_o    <= 1'b0;
         end else if (stop_i) begin
            running_o <= 1'b0;
         end else if (start_i && !running_o && !full_o) begin
            running_o <= 1'b1;
            first_q   <= 1'b1;
            ts_q      <= '0;
         end else if (running_o && tick_i) begin
            if (do_store) begin
               mem_we_o    <= 1'b1;
               mem_addr_o  <= count_q[ADDR_W-1:0];
               mem_wdata_o <= {chan_i, ts_q, stat};
               count_q     <= count_q + 1'b1;
               last_q      <= chan_i;
               ts_q        <= '0;
               first_q     <= 1'b0;
               if (count_q == LAST_ADDR) begin
                  full_o    <= 1'b1;
                  running_o <= 1'b0;
               end
            end else begin
               ts_q <= ts_q + 1'b1;
            end
         end
      end
   end

   assign wr_count_o = count_q;
endmodule

// File: rtl/xcap_top.sv
module xcap_top #(
   parameter int NCH         = 8,
   parameter int TS_W        = 16,
   parameter int ST_W        = 8,
   parameter int ADDR_W      = 18,
   parameter int TICK_DIV    = 32,
   parameter int SYNC_STAGES = 2,
   localparam int REC_W      = NCH + TS_W + ST_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              stop_i,
   input  logic              clear_i,
   input  logic [NCH-1:0]    chan_i,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [REC_W-1:0]  mem_wdata_o,
   output logic              mem_we_o,
   output logic [ADDR_W:0]   wr_count_o,
   output logic              running_o,
   output logic              full_o
);
   if (NCH < 1)   begin : g_bad_nch  $error("xcap_top: NCH must be positive"); end
   if (TS_W < 2)  begin : g_bad_ts   $error("xcap_top: TS_W must be at least 2"); end
   if (ST_W < 2)  begin : g_bad_st   $error("xcap_top: ST_W must hold two flag bits"); end
   if (ADDR_W < 1) begin : g_bad_aw  $error("xcap_top: ADDR_W must be positive"); end

   logic [NCH-1:0] chan_sync;
   logic           tick;

   xcap_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(chan_i), .q_o(chan_sync)
   );

   xcap_tick #(.DIV(TICK_DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .tick_o(tick)
   );

   xcap_record #(.NCH(NCH), .TS_W(TS_W), .ST_W(ST_W), .ADDR_W(ADDR_W)) u_rec (
      .clk(clk), .rst_n(rst_n),
      .start_i(start_i), .stop_i(stop_i), .clear_i(clear_i),
      .tick_i(tick), .chan_i(chan_sync),
      .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o),
      .wr_count_o(wr_count_o), .running_o(running_o), .full_o(full_o)
   );
endmodule

// File: rtl/xcap_checker.sv
module xcap_checker #(
   parameter int NCH    = 8,
   parameter int TS_W   = 16,
   parameter int ST_W   = 8,
   parameter int ADDR_W = 18,
   localparam int REC_W = NCH + TS_W + ST_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              stop_i,
   input logic              clear_i,
   input logic [ADDR_W-1:0] mem_addr_o,
   input logic [REC_W-1:0]  mem_wdata_o,
   input logic              mem_we_o,
   input logic [ADDR_W:0]   wr_count_o,
   input logic              running_o,
   input logic              full_o
);
   logic [NCH-1:0]  rec_data;
   logic [TS_W-1:0] rec_ts;
   logic [ST_W-1:0] rec_stat;
   logic [NCH-1:0]  prev_data;

   assign rec_data = mem_wdata_o[REC_W-1 -: NCH];
   assign rec_ts   = mem_wdata_o[ST_W +: TS_W];
   assign rec_stat = mem_wdata_o[ST_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        prev_data <= '0;
      else if (clear_i)  prev_data <= '0;
      else if (mem_we_o) prev_data <= rec_data;
   end

   p_full_halts_r8: assert property (@(posedge clk) disable iff (!rst_n)
      full_o |-> !running_o);

   p_addr_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> (wr_count_o == ({1'b0, mem_addr_o} + 1'b1)));

   p_write_needs_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we_o |-> $past(running_o));

   p_stop_halts_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_i && !clear_i) |=> (!running_o && !mem_we_o));

   p_clear_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (wr_count_o == '0 && !full_o && !running_o && !mem_we_o));

   p_first_ts_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && rec_stat[1]) |-> (rec_ts == '0));

   p_plain_is_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && rec_stat == '0) |-> (rec_data != prev_data));

   p_filler_same_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we_o && rec_stat[0]) |-> (rec_data == prev_data && rec_ts == '1));
endmodule

bind xcap_top xcap_checker #(.NCH(NCH), .TS_W(TS_W), .ST_W(ST_W), .ADDR_W(ADDR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .stop_i(stop_i), .clear_i(clear_i),
   .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_we_o(mem_we_o),
   .wr_count_o(wr_count_o), .running_o(running_o), .full_o(full_o)
);

// File: tb/xcap_top_test.sv
`timescale 1ns/1ps
module xcap_top_test;
   localparam int NCH = 8, TS_W = 4, ST_W = 8, ADDR_W = 5, DIV = 4, SYNC = 2;
   localparam int REC_W = NCH + TS_W + ST_W;
   localparam int DEPTH = 1 << ADDR_W;
   localparam int TSMAX = (1 << TS_W) - 1;

   logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, stop_i = 1'b0, clear_i = 1'b0;
   logic [NCH-1:0]    chan_i = '0;
   logic [ADDR_W-1:0] mem_addr_o;
   logic [REC_W-1:0]  mem_wdata_o;
   logic              mem_we_o;
   logic [ADDR_W:0]   wr_count_o;
   logic              running_o, full_o;

   always #2.5 clk = ~clk;

   xcap_top #(.NCH(NCH), .TS_W(TS_W), .ST_W(ST_W), .ADDR_W(ADDR_W),
              .TICK_DIV(DIV), .SYNC_STAGES(SYNC)) uut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i), .clear_i(clear_i),
      .chan_i(chan_i), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
      .mem_we_o(mem_we_o), .wr_count_o(wr_count_o), .running_o(running_o), .full_o(full_o));

   int checks = 0, fails = 0;
   int seen_ovf = 0, seen_first = 0, seen_full = 0;

   // Behavioural reference model
   int sync_q[$];
   int m_phase, m_last, m_ts, m_count;
   bit m_first, m_run, m_full, m_we;
   int m_addr, m_data, m_stat;

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         sync_q = {};
         for (int i = 0; i < SYNC; i++) sync_q.push_back(0);
         m_phase = 0; m_last = 0; m_ts = 0; m_count = 0;
         m_first = 0; m_run = 0; m_full = 0; m_we = 0;
         m_addr = 0; m_data = 0; m_stat = 0;
      end else begin
         int s;
         bit tk, chg;
         s  = sync_q[0];
         tk = (m_phase == DIV - 1);
         m_we = 0;
         if (clear_i) begin
            m_count = 0; m_last = 0; m_ts = 0; m_first = 0; m_run = 0; m_full = 0;
         end else if (stop_i) begin
            m_run = 0;
         end else if (start_i && !m_run && !m_full) begin
            m_run = 1; m_first = 1; m_ts = 0;
         end else if (m_run && tk) begin
            chg = (s != m_last);
            if (m_first || chg || m_ts == TSMAX) begin
               m_stat = (m_first ? 2 : 0) + ((!m_first && !chg) ? 1 : 0);
               m_data = (s << (TS_W + ST_W)) | (m_ts << ST_W) | m_stat;
               m_addr = m_count;
               m_we = 1;
               m_count++;
               m_last = s; m_ts = 0; m_first = 0;
               if (m_count == DEPTH) begin m_full = 1; m_run = 0; end
            end else m_ts++;
         end
         m_phase = (m_phase + 1) % DIV;
         void'(sync_q.pop_front());
         sync_q.push_back(int'(chan_i));
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         chk("R3 R10", "mem_we", mem_we_o, m_we);
         chk("R8 R10", "running", running_o, m_run);
         chk("R8", "full", full_o, m_full);
         chk("R11 R9", "wr_count", wr_count_o, m_count);
         if (m_we && mem_we_o) begin
            chk("R11", "mem_addr", mem_addr_o, m_addr);
            chk("R1 R2 R4 R5", "record", mem_wdata_o, m_data);
         end
         if (mem_we_o && mem_wdata_o[0]) seen_ovf++;
         if (mem_we_o && mem_wdata_o[1]) seen_first++;
         if (full_o) seen_full++;
      end
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse(input int which);
      @(negedge clk);
      if (which == 0) start_i = 1; else if (which == 1) stop_i = 1; else clear_i = 1;
      @(negedge clk);
      start_i = 0; stop_i = 0; clear_i = 0;
   endtask

   task automatic finish_up;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      finish_up();
   end

   initial begin
      cyc(4);
      // R11: reset state
      chk("R11", "reset we", mem_we_o, 0);
      chk("R11", "reset count", wr_count_o, 0);
      chk("R11", "reset run/full", {running_o, full_o}, 0);
      rst_n = 1;
      cyc(3);
      chan_i = 8'h3C;
      pulse(0);                       // R7 first record
      cyc(10);
      chan_i = 8'h01; cyc(9);
      chan_i = 8'hA5; cyc(3);
      cyc(90);                        // R6 filler after all-ones timestamp
      for (int i = 0; i < 6; i++) begin chan_i = chan_i ^ 8'h81; cyc(5); end
      chan_i = chan_i;                // no change: no record (R3)
      cyc(20);
      chan_i = 8'h0F; cyc(1);         // glitch shorter than a sample
      chan_i = 8'hA5 ^ 8'h81 ^ 8'h81; cyc(11);
      pulse(1);                       // R10 stop
      for (int i = 0; i < 5; i++) begin chan_i = 8'(i * 37); cyc(6); end
      chk("R10", "count frozen after stop", wr_count_o, m_count);
      pulse(0);                       // R10 resume
      for (int i = 0; i < 45; i++) begin chan_i = 8'(i * 13 + 5); cyc(4 + (i % 3) * 4); end
      chk("R8", "full reached", full_o, 1);
      chk("R8", "count at depth", wr_count_o, DEPTH);
      pulse(0);                       // R8 start ignored while full
      chan_i = ~chan_i; cyc(12);
      chk("R8", "start ignored when full", running_o, 0);
      pulse(2);                       // R9 clear
      chk("R9", "clear count", wr_count_o, 0);
      chk("R9", "clear full", full_o, 0);
      pulse(0);
      cyc(10);
      chan_i = 8'h55; cyc(8);
      chan_i = 8'hAA; cyc(8);
      chk("R9", "restart count", wr_count_o, 3);
      chk("R6", "filler records seen", int'(seen_ovf > 0), 1);
      chk("R7", "first records seen", int'(seen_first >= 3), 1);
      chk("R8", "full observed", int'(seen_full > 0), 1);
      finish_up();
   end
endmodule